// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns two asynchronous digital levels into a clean processor reset. The levels are a "supply is above its threshold" flag and an active-low manual reset request, such as a pushbutton. Reset is asserted as soon as either level, once synchronized, shows a fault. It is released only after a fixed number of clock cycles during which both levels have stayed good. Any new fault while reset is active restarts that wait from the beginning. As a result, every reset pulse has a guaranteed minimum length, and a bouncing switch yields one clean pulse.

The block drives two reset outputs: one active-high and one active-low. They are always exact complements of each other. The hold time is set by `RESET_CYCLES`, which the integrator derives from the clock frequency. For example, 50,000,000 cycles at 250 MHz gives 200 ms. Both inputs pass through a `SYNC_STAGES`-deep flop chain, which must be at least 2. While the block's own reset is applied, both chains clear to the "fault" value, so the outputs start asserted.

Top module: `supply_reset_gen`

## Requirements
- R1: While `rst_n` is low, `reset_o` is 1 and `reset_n_o` is 0, without waiting for a clock. After `rst_n` rises, reset stays asserted until the release rule of R5 is met.
- R2: On every cycle, `reset_n_o` is the logical complement of `reset_o`.
- R3: `supply_ok_i` = 0 means the supply is below threshold. Take the first rising edge that samples this 0 as edge 1. Then `reset_o` is 1 from edge `SYNC_STAGES`+1 onward, with no further delay, for as long as the input stays 0.
- R4: `man_rst_n_i` = 0 means a manual reset request. It asserts `reset_o` with the same edge timing as R3.
- R5: Take the first rising edge that samples both `supply_ok_i` = 1 and `man_rst_n_i` = 1 as edge 1, with both inputs held there afterwards. Then `reset_o` falls at edge `SYNC_STAGES`+`RESET_CYCLES` and stays 1 until then.
- R6: A fault cause that appears while reset is active restarts the hold. Release then follows R5, counted from the end of the latest cause.
- R7: A cause sampled for a single clock cycle still produces a reset pulse of at least `RESET_CYCLES` cycles.
- R8: A burst of manual presses and releases produces one continuous pulse. That pulse ends according to R5, counted from the last release.
- R9: If one cause ends on the same edge on which the other begins, reset stays asserted with no gap. Release follows R5, counted from the end of the later cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, asynchronous, active low |
| supply_ok_i | input | 1 | Asynchronous level: 1 means the supply is above its threshold |
| man_rst_n_i | input | 1 | Asynchronous manual reset request, active low |
| reset_n_o | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high, complement of `reset_n_o` |

## Verification
The supply-fault path and the manual-reset path can meet on the same clock edge. The bench provokes this in two ways. First, it releases the manual input and drops the supply flag at the same falling edge. Second, it restores the supply at the same moment a manual press begins. In both cases the scoreboard expects `reset_o` high on every cycle from the first assertion until exactly `SYNC_STAGES`+`RESET_CYCLES` edges after the later cause ends, and low afterwards. A single low cycle in the handoff, or a release timed from the earlier cause, is reported as a failure.

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int unsigned RESET_CYCLES = 50_000_000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  output logic reset_n_o,
  output logic reset_o
);

  localparam int unsigned CW = $clog2(RESET_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RESET_CYCLES);

  logic [SYNC_STAGES-1:0] sup_sync_q;
  logic [SYNC_STAGES-1:0] man_sync_q;
  logic                   sup_ok;
  logic                   man_ok;
  logic                   cause;
  logic [CW-1:0]          cnt_q;
  logic                   active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_sync_q <= '0;
      man_sync_q <= '0;
    end else begin
      sup_sync_q <= {sup_sync_q[SYNC_STAGES-2:0], supply_ok_i};
      man_sync_q <= {man_sync_q[SYNC_STAGES-2:0], man_rst_n_i};
    end
  end

  assign sup_ok = sup_sync_q[SYNC_STAGES-1];
  assign man_ok = man_sync_q[SYNC_STAGES-1];
  assign cause  = !(sup_ok && man_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= LOAD;
      active_q <= 1'b1;
    end else if (cause) begin
      cnt_q    <= LOAD;
      active_q <= 1'b1;
    end else if (cnt_q > 1) begin
      cnt_q    <= cnt_q - 1'b1;
    end else begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end
  end

  assign reset_o   = active_q;
  assign reset_n_o = ~active_q;

  logic [CW-1:0] plen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             plen_q <= '0;
    else if (!active_q)     plen_q <= '0;
    else if (plen_q != LOAD) plen_q <= plen_q + 1'b1;
  end

  AST_SUPPLY_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> reset_o); // R3
  AST_MANUAL_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    !man_ok |=> reset_o); // R4
  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_o) |-> (sup_ok && man_ok && $past(sup_ok && man_ok))); // R5
  AST_CAUSE_RESTARTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (cnt_q == LOAD)); // R6
  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_o) |-> (plen_q >= LOAD)); // R7

endmodule

// File: tb/supply_reset_gen_tb.sv
module supply_reset_gen_tb;
  localparam int unsigned RC = 20;
  localparam int unsigned SS = 2;
  localparam int LAT_A = SS + 1;
  localparam int LAT_R = SS + RC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic man_n = 1'b1;
  logic reset_n;
  logic reset;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  supply_reset_gen #(.RESET_CYCLES(RC), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .man_rst_n_i(man_n),
    .reset_n_o(reset_n), .reset_o(reset));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_span(input int from, input int to, input logic v, input string tag);
    for (int c = from; c <= to; c++) begin
      exp_t e;
      e.at = c; e.val = v; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(reset_n, ~reset, "R2 complement");
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          check(reset, sb[i].val, sb[i].tag);
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    int n;
    int q;
    tick(3);
    check(reset, 1'b1, "R1 reset_o during block reset");
    check(reset_n, 1'b0, "R1 reset_n_o during block reset");
    rst_n = 1'b1;
    n = cyc;
    expect_span(n + 1, n + 10, 1'b1, "R1 held while supply low");
    tick(10);
    n = cyc; supply_ok = 1'b1;
    expect_span(n + 1, n + LAT_R - 1, 1'b1, "R5 hold after power-up");
    expect_span(n + LAT_R, n + LAT_R + 3, 1'b0, "R5 release after power-up");
    tick(LAT_R + 6);

    n = cyc; supply_ok = 1'b0;
    expect_span(n + 1, n + LAT_A - 1, 1'b0, "R3 sync latency");
    expect_span(n + LAT_A, n + 6, 1'b1, "R3 supply fault asserts");
    tick(6);
    n = cyc; supply_ok = 1'b1;
    expect_span(n + 1, n + LAT_R - 1, 1'b1, "R5 hold after brownout");
    expect_span(n + LAT_R, n + LAT_R + 3, 1'b0, "R5 release after brownout");
    tick(LAT_R + 6);

    n = cyc; man_n = 1'b0;
    expect_span(n + 1, n + LAT_A - 1, 1'b0, "R4 sync latency");
    expect_span(n + LAT_A, n + LAT_A, 1'b1, "R4 manual asserts");
    expect_span(n + LAT_A + 1, n + LAT_R, 1'b1, "R7 one-cycle press min pulse");
    expect_span(n + LAT_R + 1, n + LAT_R + 3, 1'b0, "R7 release");
    tick(1); man_n = 1'b1;
    tick(LAT_R + 6);

    n = cyc; q = n + 13;
    expect_span(n + LAT_A, q + LAT_R - 1, 1'b1, "R8 bounce single pulse");
    expect_span(q + LAT_R, q + LAT_R + 3, 1'b0, "R8 release after last bounce");
    man_n = 1'b0; tick(2); man_n = 1'b1; tick(3); man_n = 1'b0; tick(1);
    man_n = 1'b1; tick(4); man_n = 1'b0; tick(3); man_n = 1'b1;
    tick(LAT_R + 6);

    n = cyc; q = n + 3 + (LAT_R - 8) + 2;
    expect_span(n + LAT_A, q + LAT_R - 1, 1'b1, "R6 brownout during reset extends");
    expect_span(q + LAT_R, q + LAT_R + 3, 1'b0, "R6 release after latest cause");
    supply_ok = 1'b0; tick(3); supply_ok = 1'b1; tick(LAT_R - 8);
    supply_ok = 1'b0; tick(2); supply_ok = 1'b1;
    tick(LAT_R + 6);

    n = cyc; q = n + 9;
    expect_span(n + LAT_A, q + LAT_R - 1, 1'b1, "R9 manual-to-supply handoff");
    expect_span(q + LAT_R, q + LAT_R + 3, 1'b0, "R9 release after supply");
    man_n = 1'b0; tick(4); man_n = 1'b1; supply_ok = 1'b0; tick(5); supply_ok = 1'b1;
    tick(LAT_R + 6);

    n = cyc; q = n + 7;
    expect_span(n + LAT_A, q + LAT_R - 1, 1'b1, "R9 supply-to-manual handoff");
    expect_span(q + LAT_R, q + LAT_R + 3, 1'b0, "R9 release after manual");
    supply_ok = 1'b0; tick(4); supply_ok = 1'b1; man_n = 1'b0; tick(3); man_n = 1'b1;
    tick(LAT_R + 6);

    rst_n = 1'b0;
    #1;
    check(reset, 1'b1, "R1 block reset asserts at once");
    check(reset_n, 1'b0, "R1 block reset asserts at once");
    tick(2);
    n = cyc; rst_n = 1'b1;
    expect_span(n + 1, n + LAT_R - 1, 1'b1, "R1 hold after block reset");
    expect_span(n + LAT_R, n + LAT_R + 3, 1'b0, "R1 release after block reset");
    tick(LAT_R + 6);

    foreach (sb[i]) begin
      checks++; fails++;
      $display("FAIL %s: actual unchecked expected %b (cycle %0d)", sb[i].tag, sb[i].val, sb[i].at);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished (cycle %0d)", cyc);
      summary();
      $finish;
    end
  end
endmodule